// File: doc/BRIEF.md
# Pipelined Counter Compressor Tree

This block adds K unsigned operands of W bits each and delivers their exact sum. The operands are laid out as a bit matrix, one column per bit weight. Each reduction level splits every column into groups of up to M bits and feeds each group to a parallel counter. The counter writes the number of ones in its group as a binary value, and bit j of that value lands in column c+j of the next level. A register follows every level, so the tree is a pipeline that accepts one new operand set per clock.

The schedule is greedy and fixed when the block is elaborated. A column takes as many full M-input counters as its height allows. If at least three bits are left over, they go to one smaller counter. One or two leftover bits are carried to the next level through its register. Levels are added until no column is taller than two bits. A registered carry-propagate addition of the remaining rows then gives the result. A valid flag travels beside the data with the same latency.

Top module: `ctree_sum`

## Requirements
- R1: A counter with s inputs outputs the number of its input bits that are 1, as a binary value of $clog2(s+1) bits (2 inputs gives a half adder, 3 inputs a full adder). It is truncated only where its upper bits would fall above the top result column.
- R2: `out_sum` equals the exact sum of the K operands, where operand i is `in_ops[i*W +: W]`, as a W+$clog2(K)-bit unsigned value. The top carry never overflows, including when every operand is all ones.
- R3: `out_valid` is high in exactly the cycle that carries the result of an accepted operand set. This is LAT = levels + 1 rising edges after the edge that sampled `in_valid` high: 5 for K=5, W=3, M=4 and 4 for K=8, W=8, M=8.
- R4: Each reduction level is registered, and the weighted value of the matrix it holds equals the weighted value of its input one cycle earlier.
- R5: Each column is scheduled greedily: floor(h/M) counters with M inputs, then one counter for a remainder of 3 or more bits, while a remainder of 1 or 2 bits passes through. Levels are added until every column holds at most two bits. This gives 4 levels for (5,3,4) and 3 levels for (8,8,8).
- R6: A cycle with `in_valid` low yields `out_valid` low LAT cycles later, whatever is on `in_ops`.
- R7: Synchronous active-high `rst` clears every pipeline stage. `out_valid` is low from the first edge of reset until new operands have passed through, and operand sets in flight when reset is taken never emerge.
- R8: Operand sets on consecutive cycles each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set on `in_ops` is valid this cycle |
| in_ops | input | K*W | K operands, operand i at bits i*W +: W |
| out_valid | output | 1 | `out_sum` holds a result this cycle |
| out_sum | output | W+$clog2(K) | Registered sum of the operand set |

## Verification
A counter output wired to the wrong row or column changes the weight of a bit. The sum then comes out wrong exactly LAT cycles later, but only for operand patterns that set that bit. For this reason the small configuration is swept over every operand combination, and the wide one gets random and all-ones sets. A schedule with the wrong level count, or a broken valid pipe, moves `out_valid` away from the expected cycle. This shows up on the first isolated pulse and at every idle gap. A reset that fails to clear a stage lets a result that should have been dropped show up in the cycles just after reset.

// File: rtl/ctree_pkg.sv
package ctree_pkg;

  // Upper bound on result columns handled by the elaboration-time schedule.
  localparam int MAXCOL = 64;

  // Width of a counter result for s inputs.
  function automatic int out_bits(input int s);
    return $clog2(s + 1);
  endfunction

  // Result width for k operands of w bits.
  function automatic int sum_w(input int k, input int w);
    return w + $clog2(k);
  endfunction

  // Bits of a column of height h that skip every counter.
  function automatic int pass_of(input int h, input int m);
    int r;
    r = h % m;
    return (r >= 3) ? 0 : r;
  endfunction

  // Counters placed in a column of height h.
  function automatic int ctr_num(input int h, input int m);
    return h / m + (((h % m) >= 3) ? 1 : 0);
  endfunction

  // Counters in a column of height h whose result has a bit at index j.
  function automatic int ctr_wide(input int h, input int m, input int j);
    int n;
    n = 0;
    if (j < out_bits(m)) n = n + h / m;
    if (((h % m) >= 3) && (j < out_bits(h % m))) n = n + 1;
    return n;
  endfunction

  // Height of column col at reduction level lvl (level 0 is the raw matrix).
  function automatic int col_h(input int k, input int w, input int m,
                               input int lvl, input int col);
    int h [MAXCOL];
    int g [MAXCOL];
    int sw;
    sw = sum_w(k, w);
    for (int c = 0; c < MAXCOL; c++) h[c] = (c < w) ? k : 0;
    for (int l = 0; l < lvl; l++) begin
      for (int c = 0; c < sw; c++) begin
        g[c] = pass_of(h[c], m);
        for (int j = 0; j < out_bits(m); j++)
          if (c - j >= 0) g[c] = g[c] + ctr_wide(h[c-j], m, j);
      end
      for (int c = 0; c < sw; c++) h[c] = g[c];
    end
    return h[col];
  endfunction

  // Number of counter levels until every column holds two bits or fewer.
  function automatic int num_lvls(input int k, input int w, input int m);
    int mx;
    for (int l = 0; l < MAXCOL; l++) begin
      mx = 0;
      for (int c = 0; c < sum_w(k, w); c++)
        if (col_h(k, w, m, l, c) > mx) mx = col_h(k, w, m, l, c);
      if (mx <= 2) return l;
    end
    return MAXCOL;
  endfunction

  // Tallest column over all levels: row count of the matrix buses.
  function automatic int max_h(input int k, input int w, input int m);
    int mx;
    mx = 2;
    for (int l = 0; l <= num_lvls(k, w, m); l++)
      for (int c = 0; c < sum_w(k, w); c++)
        if (col_h(k, w, m, l, c) > mx) mx = col_h(k, w, m, l, c);
    return mx;
  endfunction

  // First row in column dc of level lvl+1 that takes result bit j of the
  // counters sitting in column dc-j at level lvl.
  function automatic int dest_base(input int k, input int w, input int m,
                                   input int lvl, input int dc, input int j);
    int b;
    b = pass_of(col_h(k, w, m, lvl, dc), m);
    for (int jj = 0; jj < j; jj++)
      if (dc - jj >= 0) b = b + ctr_wide(col_h(k, w, m, lvl, dc - jj), m, jj);
    return b;
  endfunction

endpackage

// File: rtl/ctree_counter.sv
module ctree_counter #(
  parameter int M  = 8,
  parameter int OW = $clog2(M + 1)
) (
  input  logic [M-1:0]  bits,
  output logic [OW-1:0] count
);

  // Ones count accumulated modulo 2**OW; OW equals $clog2(M+1) unless the
  // upper result bits would land beyond the top result column.
  always_comb begin
    count = '0;
    for (int i = 0; i < M; i++) count = count + OW'(bits[i]);
  end

  always_comb begin
    AST_COUNT_EXACT: assert (count == OW'($countones(bits))); // R1
  end

endmodule

// File: rtl/ctree_level.sv
module ctree_level
  import ctree_pkg::*;
#(
  parameter int K    = 8,
  parameter int W    = 8,
  parameter int M    = 8,
  parameter int LVL  = 0,
  parameter int SW   = 11,
  parameter int MAXH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW*MAXH-1:0]   mat_in,
  output logic [SW*MAXH-1:0]   mat_out
);

  localparam int MB = SW * MAXH;

  // Next-level matrix: bit c*MAXH+i is row i of column c.
  wire  [MB-1:0] nxt;
  logic [MB-1:0] mat_q;

  for (genvar c = 0; c < SW; c++) begin : g_col
    localparam int H  = col_h(K, W, M, LVL, c);
    localparam int HN = col_h(K, W, M, LVL + 1, c);
    localparam int NF = H / M;
    localparam int PS = pass_of(H, M);
    localparam int NC = ctr_num(H, M);

    // Leftover bits of a short remainder move down unchanged.
    for (genvar i = 0; i < PS; i++) begin : g_pass
      assign nxt[c*MAXH + i] = mat_in[c*MAXH + NF*M + i];
    end

    // Full-width counters first, then one counter for a remainder of 3+.
    for (genvar n = 0; n < NC; n++) begin : g_ctr
      localparam int SZ = (n < NF) ? M : (H % M);
      localparam int OW = (c + out_bits(SZ) > SW) ? (SW - c) : out_bits(SZ);
      logic [OW-1:0] cnt;

      ctree_counter #(.M(SZ), .OW(OW)) u_ctr (
        .bits  (mat_in[c*MAXH + n*M +: SZ]),
        .count (cnt)
      );

      for (genvar j = 0; j < OW; j++) begin : g_out
        assign nxt[(c+j)*MAXH + dest_base(K, W, M, LVL, c + j, j) + n] = cnt[j];
      end
    end

    for (genvar i = HN; i < MAXH; i++) begin : g_zero
      assign nxt[c*MAXH + i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mat_q <= '0;
    else     mat_q <= nxt;
  end

  assign mat_out = mat_q;

  // Weighted value of a matrix, modulo 2**SW.
  function automatic logic [SW-1:0] wval(input logic [MB-1:0] v);
    logic [SW-1:0] a;
    a = '0;
    for (int c = 0; c < SW; c++)
      for (int i = 0; i < MAXH; i++)
        a = a + (SW'(v[c*MAXH + i]) << c);
    return a;
  endfunction

  AST_LEVEL_VALUE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wval(mat_q) == $past(wval(mat_in)))); // R4

endmodule

// File: rtl/ctree_final_add.sv
module ctree_final_add #(
  parameter int SW   = 11,
  parameter int MAXH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SW*MAXH-1:0] mat,
  output logic [SW-1:0]      sum
);

  localparam int AW = SW + $clog2(MAXH);

  // Only rows 0 and 1 are non-constant after reduction; the constant-zero
  // rows fold away, leaving a two-input carry-propagate adder.
  logic [AW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < MAXH; i++)
      for (int c = 0; c < SW; c++)
        acc = acc + (AW'(mat[c*MAXH + i]) << c);
  end

  always_ff @(posedge clk) begin
    if (rst) sum <= '0;
    else     sum <= acc[SW-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    acc[AW-1:SW] == '0); // R2

endmodule

// File: rtl/ctree_sum.sv
module ctree_sum
  import ctree_pkg::*;
#(
  parameter int K = 8,
  parameter int W = 8,
  parameter int M = 8,
  localparam int SW = W + $clog2(K)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [K*W-1:0] in_ops,
  output logic           out_valid,
  output logic [SW-1:0]  out_sum
);

  localparam int NL   = num_lvls(K, W, M);
  localparam int MAXH = max_h(K, W, M);
  localparam int LAT  = NL + 1;
  localparam int MB   = SW * MAXH;
  localparam int WCW  = $clog2(LAT + 1);

  // Level-0 matrix: column c holds bit c of every operand.
  wire [MB-1:0] mat0;
  wire [MB-1:0] lvl_mat [NL+1];

  for (genvar c = 0; c < SW; c++) begin : g_mcol
    for (genvar i = 0; i < MAXH; i++) begin : g_mrow
      if (c < W && i < K) begin : g_bit
        assign mat0[c*MAXH + i] = in_ops[i*W + c];
      end else begin : g_pad
        assign mat0[c*MAXH + i] = 1'b0;
      end
    end
  end

  assign lvl_mat[0] = mat0;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    ctree_level #(
      .K(K), .W(W), .M(M), .LVL(l), .SW(SW), .MAXH(MAXH)
    ) u_lvl (
      .clk     (clk),
      .rst     (rst),
      .mat_in  (lvl_mat[l]),
      .mat_out (lvl_mat[l+1])
    );
  end

  ctree_final_add #(.SW(SW), .MAXH(MAXH)) u_fin (
    .clk (clk),
    .rst (rst),
    .mat (lvl_mat[NL]),
    .sum (out_sum)
  );

  // Valid flag delayed by the reduction levels plus the final adder.
  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= (vpipe << 1) | LAT'(in_valid);
  end

  assign out_valid = vpipe[LAT-1];

  // Cycles since reset, saturating at LAT; only used to arm the alignment check.
  logic [WCW-1:0] warm;

  always_ff @(posedge clk) begin
    if (rst)                     warm <= '0;
    else if (warm != WCW'(LAT))  warm <= warm + 1'b1;
  end

  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (warm == WCW'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R3

  AST_VALID_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R7

endmodule

// File: tb/ctree_sum_test.sv
module ctree_sum_test;

  localparam int CLK_PERIOD = 10;

  // Small configuration: swept over every operand combination.
  localparam int K1 = 5, W1 = 3, M1 = 4, SW1 = 6, LAT1 = 5;
  // Wide configuration (block defaults): random and corner operands.
  localparam int K2 = 8, W2 = 8, M2 = 8, SW2 = 11, LAT2 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             v1 = 1'b0, v2 = 1'b0;
  logic [K1*W1-1:0] ops1 = '0;
  logic [K2*W2-1:0] ops2 = '0;
  wire              ov1, ov2;
  wire  [SW1-1:0]   s1;
  wire  [SW2-1:0]   s2;

  ctree_sum #(.K(K1), .W(W1), .M(M1)) uut (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ops(ops1),
    .out_valid(ov1), .out_sum(s1)
  );

  ctree_sum #(.K(K2), .W(W2), .M(M2)) uut_wide (
    .clk(clk), .rst(rst), .in_valid(v2), .in_ops(ops2),
    .out_valid(ov2), .out_sum(s2)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // Expected-result rings indexed by drive cycle; why: 0 idle, 1 valid, 2 reset.
  bit r1_v [16]; int r1_s [16]; int r1_why [16];
  bit r2_v [16]; int r2_s [16]; int r2_why [16];

  function automatic int add1(input logic [K1*W1-1:0] o);
    int s = 0;
    for (int i = 0; i < K1; i++) s += int'(o[i*W1 +: W1]);
    return s;
  endfunction

  function automatic int add2(input logic [K2*W2-1:0] o);
    int s = 0;
    for (int i = 0; i < K2; i++) s += int'(o[i*W2 +: W2]);
    return s;
  endfunction

  function automatic string why_tag(input int w);
    if (w == 0) return "R6 idle slot";
    if (w == 1) return "R3/R5 latency";
    return "R7 reset flush";
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // One cycle: check outputs at the falling edge, then drive the next inputs.
  task automatic step(input bit r, input bit a1, input logic [K1*W1-1:0] o1,
                      input bit a2, input logic [K2*W2-1:0] o2, input string tag);
    int i1, i2;
    @(negedge clk);
    i1 = (cyc + 16 - LAT1) % 16;
    i2 = (cyc + 16 - LAT2) % 16;
    chk({why_tag(r1_why[i1]), " small out_valid"}, int'(ov1), int'(r1_v[i1]));
    if (r1_v[i1]) chk({tag, " small out_sum"}, int'(s1), r1_s[i1]);
    chk({why_tag(r2_why[i2]), " wide out_valid"}, int'(ov2), int'(r2_v[i2]));
    if (r2_v[i2]) chk({tag, " wide out_sum"}, int'(s2), r2_s[i2]);
    rst = r; v1 = a1; ops1 = o1; v2 = a2; ops2 = o2;
    if (r) begin
      for (int i = 0; i < 16; i++) begin
        r1_v[i] = 1'b0; r1_why[i] = 2;
        r2_v[i] = 1'b0; r2_why[i] = 2;
      end
    end
    r1_v[cyc % 16]   = a1 && !r;
    r1_s[cyc % 16]   = add1(o1);
    r1_why[cyc % 16] = r ? 2 : (a1 ? 1 : 0);
    r2_v[cyc % 16]   = a2 && !r;
    r2_s[cyc % 16]   = add2(o2);
    r2_why[cyc % 16] = r ? 2 : (a2 ? 1 : 0);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '1, 1'b0, '1, "R6");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      r1_v[i] = 1'b0; r1_s[i] = 0; r1_why[i] = 2;
      r2_v[i] = 1'b0; r2_s[i] = 0; r2_why[i] = 2;
    end

    // R7: reset state, outputs quiet.
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, 1'b0, '0, "R7");

    // R2 R8 R1: every small operand combination, with idle gaps (R6) whose
    // operands are all ones; the wide block gets a back-to-back stream.
    for (int idx = 0; idx < 32768; idx++) begin
      logic [K2*W2-1:0] w;
      if (idx % 7 == 3) step(1'b0, 1'b0, '1, 1'b1, {$urandom, $urandom}, "R6 R8");
      if (idx % 50 == 0)      w = '1;
      else if (idx % 37 == 0) w = '0;
      else                    w = {$urandom, $urandom};
      step(1'b0, 1'b1, (K1*W1)'(idx), 1'b1, w, "R2 R8");
    end

    // R3 R5: isolated all-ones pulse; valid must appear exactly LAT later.
    idle(8);
    step(1'b0, 1'b1, '1, 1'b1, '1, "R1 R2 all-ones");
    idle(8);

    // R7: reset taken with results in flight; none may emerge.
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b1, (K1*W1)'(i * 4099 + 7), 1'b1, {$urandom, $urandom}, "R2");
    step(1'b1, 1'b1, '1, 1'b1, '1, "R7");
    step(1'b1, 1'b1, '1, 1'b1, '1, "R7");
    idle(8);
    step(1'b0, 1'b1, '1, 1'b1, '1, "R2 after reset");
    idle(8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule